// File: doc/BRIEF.md
# Five-Stage Pipelined Integer Core

This block executes a six-instruction, 32-bit integer subset: add, subtract, OR with an immediate, load word, store word and branch-if-equal. It is built as a five-stage pipeline:

- fetch
- decode with register read
- execute
- memory
- write-back

Registers sit between adjacent stages, and all of them advance on one clock edge. Up to five instructions are in flight at once, and one can retire per clock. Control is decoded once in decode and carried forward with each instruction. Each later stage uses only the control fields it needs.

The instruction memory and the data memory are outside the block. Each is reached through a plain address/data port that answers in the same cycle, so neither port has a valid/ready handshake or back-pressure. The fetch address advances every cycle unless a branch redirects it.

There is no hazard detection and no forwarding between stages. Software must separate a producer from a consumer by at least two other instructions. A taken branch discards the two instructions fetched after it.

Top module: `pipe5_core`

## Requirements
- R1: In straight-line code the fetch address starts at 0 after reset and grows by 4 on every clock, so one instruction enters the pipeline per cycle.
- R2: Opcode field [31:26] = 0x00 selects the register form. Function field [5:0] = 0x20 writes rs+rt into register rd, and 0x22 writes rs-rt into rd. The fields are rs = [25:21], rt = [20:16] and rd = [15:11].
- R3: Opcode 0x0D writes rs OR the zero-extended 16-bit immediate [15:0] into rt.
- R4: Opcode 0x23 loads the data word at rs plus the sign-extended immediate into rt. Opcode 0x2B stores rt to that same address. The address is formed in execute and memory is accessed one stage later.
- R5: Opcode 0x04 with rs equal to rt is taken. The next fetch is then from pc+4+(sign-extended immediate × 4), three cycles after the branch was fetched. The two instructions fetched after the branch have no effect.
- R6: A branch-if-equal whose operands differ changes nothing, and fetch continues in order.
- R7: A register written in write-back is read with its new value by an instruction decoded in that same cycle. A consumer placed three instructions after its producer therefore sees the result.
- R8: Register 0 always reads as zero, and writes to it are discarded.
- R9: Reset empties every stage into a bubble that writes neither registers nor memory. The first store in a program reaches the data port in cycle 3 and not before.
- R10: Any encoding outside the six listed is a no-op; this includes the all-zero word.
- R11: Write-back uses the destination register and write enable that travelled with the retiring instruction, not those of the instruction in decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| imem_addr | output | 32 | Byte address of the instruction being fetched |
| imem_rdata | input | 32 | Instruction word at imem_addr, same cycle |
| dmem_addr | output | 32 | Byte address of the data access in the memory stage |
| dmem_we | output | 1 | Store strobe; the word is written at the clock edge |
| dmem_wdata | output | 32 | Store data |
| dmem_rdata | input | 32 | Data word at dmem_addr, same cycle |

## Verification
The assertions watch the following on every cycle:

- the fetch sequencing: a +4 step, or a jump to the computed target in the cycle after a taken branch;
- the emptying of the two younger stages after a taken branch;
- the hand-off of destination register and write enable from the memory stage to write-back;
- the bubble state that reset leaves.

The arithmetic results, operand extension, effective addresses, the same-cycle register write/read, the discarding of writes to register 0 and the no-op decoding of unknown words show only in memory contents. The bench's program scenarios read those back through the data port.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;
  localparam int XLEN = 32;
  localparam int RIDX = 5;
  localparam int NREG = 1 << RIDX;
  localparam int IMMW = 16;

  localparam logic [5:0] OP_REG  = 6'h00;
  localparam logic [5:0] OP_ORI  = 6'h0D;
  localparam logic [5:0] OP_LOAD = 6'h23;
  localparam logic [5:0] OP_STOR = 6'h2B;
  localparam logic [5:0] OP_BREQ = 6'h04;
  localparam logic [5:0] FN_ADD  = 6'h20;
  localparam logic [5:0] FN_SUB  = 6'h22;

  typedef enum logic [1:0] {ALU_ADD = 2'd0, ALU_SUB = 2'd1, ALU_OR = 2'd2} alu_op_e;

  typedef struct packed {
    logic    reg_wr;
    logic    dst_rd;
    logic    alu_imm;
    logic    sign_ext;
    logic    mem_wr;
    logic    mem_to_reg;
    logic    branch;
    alu_op_e alu_op;
  } ctrl_t;

  localparam ctrl_t CTRL_NOP = '0;

  typedef struct packed {
    logic            valid;
    logic [XLEN-1:0] instr;
    logic [XLEN-1:0] pc4;
  } ifid_t;

  typedef struct packed {
    logic            valid;
    ctrl_t           ctrl;
    logic [XLEN-1:0] opa;
    logic [XLEN-1:0] opb;
    logic [XLEN-1:0] imm;
    logic [RIDX-1:0] dest;
    logic [XLEN-1:0] pc4;
  } idex_t;

  typedef struct packed {
    logic            valid;
    logic            reg_wr;
    logic            mem_wr;
    logic            mem_to_reg;
    logic [XLEN-1:0] res;
    logic [XLEN-1:0] sdata;
    logic [RIDX-1:0] dest;
  } exmem_t;

  typedef struct packed {
    logic            valid;
    logic            reg_wr;
    logic [RIDX-1:0] dest;
    logic [XLEN-1:0] data;
  } memwb_t;
endpackage

// File: rtl/pipe5_decode.sv
module pipe5_decode
  import pipe5_pkg::*;
(
  input  logic [XLEN-1:0] instr,
  input  logic            valid,
  output ctrl_t           ctrl,
  output logic [RIDX-1:0] rs,
  output logic [RIDX-1:0] rt,
  output logic [RIDX-1:0] dest,
  output logic [XLEN-1:0] imm_ext
);
  logic [5:0]      opcode;
  logic [5:0]      funct;
  logic [RIDX-1:0] rd;
  logic [IMMW-1:0] imm;

  assign opcode = instr[31:26];
  assign funct  = instr[5:0];
  assign rs     = instr[25:21];
  assign rt     = instr[20:16];
  assign rd     = instr[15:11];
  assign imm    = instr[IMMW-1:0];

  always_comb begin
    ctrl = CTRL_NOP;
    if (valid) begin
      case (opcode)
        OP_REG: begin
          if (funct == FN_ADD) begin
            ctrl.reg_wr = 1'b1;
            ctrl.dst_rd = 1'b1;
            ctrl.alu_op = ALU_ADD;
          end else if (funct == FN_SUB) begin
            ctrl.reg_wr = 1'b1;
            ctrl.dst_rd = 1'b1;
            ctrl.alu_op = ALU_SUB;
          end
        end
        OP_ORI: begin
          ctrl.reg_wr  = 1'b1;
          ctrl.alu_imm = 1'b1;
          ctrl.alu_op  = ALU_OR;
        end
        OP_LOAD: begin
          ctrl.reg_wr     = 1'b1;
          ctrl.alu_imm    = 1'b1;
          ctrl.sign_ext   = 1'b1;
          ctrl.mem_to_reg = 1'b1;
          ctrl.alu_op     = ALU_ADD;
        end
        OP_STOR: begin
          ctrl.mem_wr   = 1'b1;
          ctrl.alu_imm  = 1'b1;
          ctrl.sign_ext = 1'b1;
          ctrl.alu_op   = ALU_ADD;
        end
        OP_BREQ: begin
          ctrl.branch   = 1'b1;
          ctrl.sign_ext = 1'b1;
          ctrl.alu_op   = ALU_SUB;
        end
        default: ctrl = CTRL_NOP;
      endcase
    end
  end

  assign imm_ext = ctrl.sign_ext ? {{(XLEN-IMMW){imm[IMMW-1]}}, imm}
                                 : {{(XLEN-IMMW){1'b0}}, imm};
  assign dest    = ctrl.dst_rd ? rd : rt;
endmodule

// File: rtl/pipe5_regfile.sv
module pipe5_regfile #(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] regs [DEPTH];
  logic         wr_live;

  assign wr_live = we && (waddr != '0);

  always_ff @(posedge clk) begin
    if (wr_live) regs[waddr] <= wdata;
  end

  // A write landing this cycle is seen by a read of the same index
  function automatic logic [W-1:0] rd_port(input logic [AW-1:0] ra);
    if (ra == '0)                  return '0;
    else if (wr_live && ra == waddr) return wdata;
    else                           return regs[ra];
  endfunction

  assign rdata_a = rd_port(raddr_a);
  assign rdata_b = rd_port(raddr_b);
endmodule

// File: rtl/pipe5_alu.sv
module pipe5_alu
  import pipe5_pkg::*;
(
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y,
  output logic            eq
);
  always_comb begin
    case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_OR:  y = a | b;
      default: y = '0;
    endcase
  end
  assign eq = (a == b);
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
  import pipe5_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_rdata,
  output logic [31:0] dmem_addr,
  output logic        dmem_we,
  output logic [31:0] dmem_wdata,
  input  logic [31:0] dmem_rdata
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0] pc_q;
  ifid_t           ifid_q;
  idex_t           idex_q;
  exmem_t          exmem_q;
  memwb_t          memwb_q;

  // fetch
  logic [XLEN-1:0] pc_plus4;
  assign pc_plus4  = pc_q + STEP;
  assign imem_addr = pc_q;

  // decode
  ctrl_t           id_ctrl;
  logic [RIDX-1:0] id_rs, id_rt, id_dest;
  logic [XLEN-1:0] id_imm, id_opa, id_opb;

  pipe5_decode u_dec (
    .instr   (ifid_q.instr),
    .valid   (ifid_q.valid),
    .ctrl    (id_ctrl),
    .rs      (id_rs),
    .rt      (id_rt),
    .dest    (id_dest),
    .imm_ext (id_imm)
  );

  logic            wb_we;
  assign wb_we = memwb_q.valid && memwb_q.reg_wr;

  pipe5_regfile #(.W(XLEN), .AW(RIDX)) u_rf (
    .clk     (clk),
    .we      (wb_we),
    .waddr   (memwb_q.dest),
    .wdata   (memwb_q.data),
    .raddr_a (id_rs),
    .raddr_b (id_rt),
    .rdata_a (id_opa),
    .rdata_b (id_opb)
  );

  // execute
  logic [XLEN-1:0] ex_b, ex_res, br_target;
  logic            ex_eq, ex_taken;

  assign ex_b = idex_q.ctrl.alu_imm ? idex_q.imm : idex_q.opb;

  pipe5_alu u_alu (
    .op (idex_q.ctrl.alu_op),
    .a  (idex_q.opa),
    .b  (ex_b),
    .y  (ex_res),
    .eq (ex_eq)
  );

  assign ex_taken  = idex_q.valid && idex_q.ctrl.branch && ex_eq;
  assign br_target = idex_q.pc4 + {idex_q.imm[XLEN-3:0], 2'b00};

  // memory
  assign dmem_addr  = exmem_q.res;
  assign dmem_wdata = exmem_q.sdata;
  assign dmem_we    = exmem_q.valid && exmem_q.mem_wr;

  // flat views for the bound checker
  logic            ifid_vld, idex_vld, exmem_vld, memwb_vld;
  logic            exmem_rw, memwb_rw;
  logic [RIDX-1:0] exmem_dst, memwb_dst;
  assign ifid_vld  = ifid_q.valid;
  assign idex_vld  = idex_q.valid;
  assign exmem_vld = exmem_q.valid;
  assign memwb_vld = memwb_q.valid;
  assign exmem_rw  = exmem_q.reg_wr;
  assign memwb_rw  = memwb_q.reg_wr;
  assign exmem_dst = exmem_q.dest;
  assign memwb_dst = memwb_q.dest;

  // stage registers, all on one edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q    <= RESET_PC;
      ifid_q  <= '0;
      idex_q  <= '0;
      exmem_q <= '0;
      memwb_q <= '0;
    end else begin
      pc_q <= ex_taken ? br_target : pc_plus4;

      if (ex_taken) begin
        ifid_q <= '0;
        idex_q <= '0;
      end else begin
        ifid_q.valid <= 1'b1;
        ifid_q.instr <= imem_rdata;
        ifid_q.pc4   <= pc_plus4;

        idex_q.valid <= ifid_q.valid;
        idex_q.ctrl  <= id_ctrl;
        idex_q.opa   <= id_opa;
        idex_q.opb   <= id_opb;
        idex_q.imm   <= id_imm;
        idex_q.dest  <= id_dest;
        idex_q.pc4   <= ifid_q.pc4;
      end

      exmem_q.valid      <= idex_q.valid;
      exmem_q.reg_wr     <= idex_q.ctrl.reg_wr;
      exmem_q.mem_wr     <= idex_q.ctrl.mem_wr;
      exmem_q.mem_to_reg <= idex_q.ctrl.mem_to_reg;
      exmem_q.res        <= ex_res;
      exmem_q.sdata      <= idex_q.opb;
      exmem_q.dest       <= idex_q.dest;

      memwb_q.valid  <= exmem_q.valid;
      memwb_q.reg_wr <= exmem_q.reg_wr;
      memwb_q.dest   <= exmem_q.dest;
      memwb_q.data   <= exmem_q.mem_to_reg ? dmem_rdata : exmem_q.res;
    end
  end
endmodule

// File: rtl/pipe5_core_chk.sv
module pipe5_core_chk #(
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] imem_addr,
  input logic        dmem_we,
  input logic        ex_taken,
  input logic [31:0] br_target,
  input logic        ifid_vld,
  input logic        idex_vld,
  input logic        exmem_vld,
  input logic        memwb_vld,
  input logic        exmem_rw,
  input logic        memwb_rw,
  input logic [4:0]  exmem_dst,
  input logic [4:0]  memwb_dst
);
  // R1: sequential fetch steps by one word
  a_r1_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_taken |=> imem_addr == $past(imem_addr) + 32'd4);

  // R5: taken branch redirects fetch to its target
  a_r5_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    ex_taken |=> imem_addr == $past(br_target));

  // R5: the two younger instructions become bubbles
  a_r5_squash: assert property (@(posedge clk) disable iff (!rst_n)
    ex_taken |=> (!ifid_vld && !idex_vld));

  // R11: destination and write enable move with the instruction
  a_r11_dest_travel: assert property (@(posedge clk) disable iff (!rst_n)
    exmem_vld |=> (memwb_vld && memwb_dst == $past(exmem_dst)
                   && memwb_rw == $past(exmem_rw)));

  // R9: reset leaves bubbles and the start address
  a_r9_reset_bubble: assert property (@(posedge clk)
    !rst_n |=> (!dmem_we && !ifid_vld && !idex_vld && !exmem_vld
                && !memwb_vld && imem_addr == RESET_PC));
endmodule

bind pipe5_core pipe5_core_chk #(.RESET_PC(RESET_PC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .imem_addr (imem_addr),
  .dmem_we   (dmem_we),
  .ex_taken  (ex_taken),
  .br_target (br_target),
  .ifid_vld  (ifid_vld),
  .idex_vld  (idex_vld),
  .exmem_vld (exmem_vld),
  .memwb_vld (memwb_vld),
  .exmem_rw  (exmem_rw),
  .memwb_rw  (memwb_rw),
  .exmem_dst (exmem_dst),
  .memwb_dst (memwb_dst)
);

// File: tb/pipe5_core_bench.sv
`timescale 1ns/1ps
module pipe5_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MWORDS = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;

  logic [31:0] imem [MWORDS];
  logic [31:0] dmem [MWORDS];
  logic [31:0] tr_pc [MWORDS];
  logic        tr_we [MWORDS];

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pipe5_core u_pipe5_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_addr  (dmem_addr),
    .dmem_we    (dmem_we),
    .dmem_wdata (dmem_wdata),
    .dmem_rdata (dmem_rdata)
  );

  assign imem_rdata = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

  // encoders
  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd,
                                        input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs,
                                        input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < MWORDS; i++) begin
      imem[i] = 32'h0;
      dmem[i] <= 32'h0;
    end
  endtask

  task automatic run_prog(input int ncyc);
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    for (int k = 0; k < ncyc; k++) begin
      tr_pc[k] = imem_addr;
      tr_we[k] = dmem_we;
      @(negedge clk);
      #1;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    clear_mem();
    for (int i = 0; i < 4; i++) imem[i] = enc_i(6'h2B, 0, 0, 16'h0010);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R9 pc in reset", imem_addr, 32'h0);
    check("R9 no store in reset", {31'b0, dmem_we}, 32'h0);
    run_prog(6);
    for (int k = 0; k < 3; k++) check("R9 bubble store strobe", {31'b0, tr_we[k]}, 32'h0);
    check("R9 first store in cycle 3", {31'b0, tr_we[3]}, 32'h1);
  endtask

  task automatic t_arith();
    clear_mem();
    imem[0]  = enc_i(6'h0D, 0, 1, 16'h1234);
    imem[1]  = enc_i(6'h0D, 0, 2, 16'h0F0F);
    imem[4]  = enc_r(1, 2, 3, 6'h20);
    imem[5]  = enc_r(1, 2, 4, 6'h22);
    imem[6]  = enc_i(6'h0D, 0, 5, 16'h8000);
    imem[9]  = enc_i(6'h2B, 0, 3, 16'h0000);
    imem[10] = enc_i(6'h2B, 0, 4, 16'h0004);
    imem[11] = enc_i(6'h2B, 0, 5, 16'h0008);
    run_prog(20);
    check("R2 add", dmem[0], 32'h0000_2143);
    check("R2 sub", dmem[1], 32'h0000_0325);
    check("R3 ori zero-extend", dmem[2], 32'h0000_8000);
    check("R11 independent back-to-back results", dmem[0] ^ dmem[1], 32'h2143 ^ 32'h0325);
    for (int k = 0; k < 12; k++) check("R1 fetch step", tr_pc[k], 32'(4 * k));
  endtask

  task automatic t_mem();
    clear_mem();
    dmem[8] <= 32'hCAFE_F00D;
    imem[0] = enc_i(6'h23, 0, 2, 16'h0020);
    imem[1] = enc_i(6'h0D, 0, 6, 16'h0050);
    imem[3] = enc_i(6'h2B, 0, 2, 16'h0024);
    imem[4] = enc_i(6'h2B, 6, 6, 16'hFFF8);
    run_prog(16);
    check("R4 load then store (R7 same-cycle read)", dmem[9], 32'hCAFE_F00D);
    check("R4 negative offset store (R7)", dmem[18], 32'h0000_0050);
  endtask

  task automatic t_zero();
    clear_mem();
    dmem[12] <= 32'hFFFF_FFFF;
    imem[0] = enc_i(6'h0D, 0, 0, 16'h0055);
    imem[1] = {6'h3F, 26'h0};
    imem[2] = enc_i(6'h0D, 0, 9, 16'h0011);
    imem[3] = enc_r(0, 0, 9, 6'h3F);
    imem[6] = enc_i(6'h2B, 0, 0, 16'h0030);
    imem[7] = enc_i(6'h2B, 0, 9, 16'h0034);
    run_prog(16);
    check("R8 r0 stays zero", dmem[12], 32'h0);
    check("R10 unknown funct leaves r9", dmem[13], 32'h0000_0011);
    check("R10 unknown opcode no store", dmem[0], 32'h0);
  endtask

  task automatic t_taken();
    clear_mem();
    imem[0]  = enc_i(6'h0D, 0, 1, 16'h0005);
    imem[1]  = enc_i(6'h0D, 0, 2, 16'h0005);
    imem[2]  = enc_i(6'h0D, 0, 3, 16'h0001);
    imem[3]  = enc_i(6'h0D, 0, 4, 16'h0001);
    imem[4]  = enc_i(6'h0D, 0, 8, 16'h0001);
    imem[5]  = enc_i(6'h04, 1, 2, 16'h0003);
    imem[6]  = enc_i(6'h0D, 0, 3, 16'h0BAD);
    imem[7]  = enc_i(6'h0D, 0, 4, 16'h0BAD);
    imem[8]  = enc_i(6'h0D, 0, 8, 16'h0BAD);
    imem[9]  = enc_i(6'h0D, 0, 9, 16'h0077);
    imem[12] = enc_i(6'h2B, 0, 3, 16'h0040);
    imem[13] = enc_i(6'h2B, 0, 4, 16'h0044);
    imem[14] = enc_i(6'h2B, 0, 8, 16'h0048);
    imem[15] = enc_i(6'h2B, 0, 9, 16'h004C);
    run_prog(30);
    check("R5 pc in branch execute cycle", tr_pc[7], 32'd28);
    check("R5 pc redirected", tr_pc[8], 32'd36);
    check("R5 first squashed slot", dmem[16], 32'h1);
    check("R5 second squashed slot", dmem[17], 32'h1);
    check("R5 skipped instruction", dmem[18], 32'h1);
    check("R5 target executes", dmem[19], 32'h77);
  endtask

  task automatic t_not_taken();
    clear_mem();
    imem[0]  = enc_i(6'h0D, 0, 1, 16'h0005);
    imem[1]  = enc_i(6'h0D, 0, 2, 16'h0006);
    imem[4]  = enc_i(6'h04, 1, 2, 16'h0003);
    imem[5]  = enc_i(6'h0D, 0, 3, 16'h0021);
    imem[6]  = enc_i(6'h0D, 0, 4, 16'h0022);
    imem[7]  = enc_i(6'h0D, 0, 5, 16'h0023);
    imem[10] = enc_i(6'h2B, 0, 3, 16'h0050);
    imem[11] = enc_i(6'h2B, 0, 4, 16'h0054);
    imem[12] = enc_i(6'h2B, 0, 5, 16'h0058);
    run_prog(22);
    check("R6 slot 1 runs", dmem[20], 32'h21);
    check("R6 slot 2 runs", dmem[21], 32'h22);
    check("R6 slot 3 runs", dmem[22], 32'h23);
    for (int k = 0; k < 13; k++) check("R6 in-order fetch", tr_pc[k], 32'(4 * k));
  endtask

  initial begin
    t_reset();
    t_arith();
    t_mem();
    t_zero();
    t_taken();
    t_not_taken();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule